// File: doc/BRIEF.md
# Closed-Caption Line Data Inserter

This block produces the serial caption waveform for the caption line of each video field. The video timing logic supplies a field indicator, a line number, a format select (NTSC or PAL) and a horizontal counter that advances by one every pixel clock. When the current line is the caption line of the current field and insertion is enabled for that field, the block sends a caption window. The window starts one edge after the horizontal counter reaches a programmed start position. The window holds seven clock run-in periods, the start bits 0, 0, 1 and then sixteen data bits. The data bits are the first caption byte and then the second, each sent least significant bit first.

Caption bytes arrive on a small valid/ready stream, with both bytes of one field in each transfer. Every field has a pending copy and an in-use copy. An accepted transfer writes only the pending copy. The in-use copy is reloaded from the pending copy when that field's window starts, so a write never disturbs a window that is already running. `cap_ready` drops for exactly one cycle: the cycle in which the horizontal counter equals the start position. A transfer offered in that cycle is held until the next cycle. The output pair (`cc_valid`, `cc_bit`) is a flow-through level that the luma path scales to caption amplitude. It has no back-pressure, because video timing cannot stall.

Top module: `cc_line_inserter`

## Requirements
- R1: With `field_id`=0, a window is produced only on line 21 when `fmt_pal`=0 and only on line 22 when `fmt_pal`=1, using the field-1 bytes.
- R2: With `field_id`=1, a window is produced only on line 284 when `fmt_pal`=0 and only on line 335 when `fmt_pal`=1, using the field-2 bytes.
- R3: `cc_valid` rises on the edge that samples `hcount`==START_H on a matching line. It stays high for exactly 26×BIT_CLKS cycles.
- R4: Bit periods 0 to 6 of the window are run-in. In each of them `cc_bit` is 1 for the first floor(BIT_CLKS/2) clocks and 0 for the remaining clocks.
- R5: Bit periods 7, 8 and 9 carry the start bits 0, 0, 1.
- R6: Bit periods 10 to 17 carry byte 1 (`cap_byte1`), bit 0 first. Bit periods 18 to 25 carry byte 2 (`cap_byte2`), bit 0 first.
- R7: `cc_valid` and `cc_bit` are 0 outside the window, on every non-caption line, after reset, and when the field indicator does not match the line.
- R8: If `en_f1` is low, no window is produced on the field-1 caption line. If `en_f2` is low, none is produced on the field-2 caption line. Both outputs stay 0 on that line.
- R9: A transfer accepted while a window is running does not change that window. Its bytes are used from the next caption line of the field named by `cap_field` (0 = field 1, 1 = field 2), and the other field's bytes are not affected.
- R10: `cap_ready` is 0 in exactly the cycles where `hcount` equals START_H and is 1 otherwise. A transfer is taken when `cap_valid` and `cap_ready` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hcount | input | H_W | Horizontal pixel counter, +1 per clock |
| line_num | input | LINE_W | Current line number |
| field_id | input | 1 | 0 = field 1, 1 = field 2 |
| fmt_pal | input | 1 | 0 = NTSC lines, 1 = PAL lines |
| en_f1 | input | 1 | Enable insertion for field 1 |
| en_f2 | input | 1 | Enable insertion for field 2 |
| cap_valid | input | 1 | Caption transfer offered |
| cap_ready | output | 1 | Caption transfer can be taken |
| cap_field | input | 1 | Target field of the transfer |
| cap_byte1 | input | 8 | First caption byte |
| cap_byte2 | input | 8 | Second caption byte |
| cc_valid | output | 1 | Caption window active |
| cc_bit | output | 1 | Caption data level |

## Verification
`cc_valid` and `cc_bit` are due one clock edge after the `hcount` value they belong to. For each driven `hcount` h, the bench therefore samples just after the following rising edge and compares against bit period (h−START_H)/BIT_CLKS at phase (h−START_H) mod BIT_CLKS. `cap_ready` is combinational and is checked in the same cycle that `hcount` is driven, before the edge. For R9, accepted bytes are expected to appear only from the next window start of their field, so a write made in the middle of a window is expected to leave that window's remaining bits unchanged.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int RUNIN_SLOTS = 7;
  localparam int START_SLOTS = 3;
  localparam int DATA_BITS   = 16;
  localparam int TOTAL_SLOTS = RUNIN_SLOTS + START_SLOTS + DATA_BITS;

  localparam int NTSC_F1_LINE = 21;
  localparam int PAL_F1_LINE  = 22;
  localparam int NTSC_F2_LINE = 284;
  localparam int PAL_F2_LINE  = 335;

  function automatic int caption_line(input logic fld, input logic pal);
    if (!fld) return pal ? PAL_F1_LINE : NTSC_F1_LINE;
    else      return pal ? PAL_F2_LINE : NTSC_F2_LINE;
  endfunction
endpackage

// File: rtl/cc_line_match.sv
module cc_line_match #(
  parameter int LINE_W = 10
) (
  input  logic              field_id,
  input  logic              fmt_pal,
  input  logic [LINE_W-1:0] line_num,
  input  logic              en_f1,
  input  logic              en_f2,
  output logic              hit
);
  logic [LINE_W-1:0] target;
  logic              fld_en;

  always_comb begin
    target = LINE_W'(cc_pkg::caption_line(field_id, fmt_pal));
    fld_en = field_id ? en_f2 : en_f1;
    hit    = fld_en && (line_num == target);
  end
endmodule

// File: rtl/cc_shadow_bank.sv
module cc_shadow_bank #(
  parameter int NF = 2,
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(NF)-1:0] wr_field,
  input  logic [DW-1:0]         wr_word,
  input  logic                  load,
  input  logic [$clog2(NF)-1:0] load_field,
  input  logic [$clog2(NF)-1:0] sel_field,
  input  logic                  active_in,
  output logic [DW-1:0]         live_word
);
  localparam int FW = $clog2(NF);

  logic [DW-1:0] pend_q [NF];
  logic [DW-1:0] live_q [NF];

  for (genvar gf = 0; gf < NF; gf++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[gf] <= '0;
        live_q[gf] <= '0;
      end else begin
        if (wr_en && wr_field == FW'(gf)) pend_q[gf] <= wr_word;
        if (load && load_field == FW'(gf)) live_q[gf] <= pend_q[gf];
      end
    end

    // R9
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_in && $past(active_in)) |-> $stable(live_q[gf]));
  end

  assign live_word = live_q[sel_field];
endmodule

// File: rtl/cc_serializer.sv
module cc_serializer #(
  parameter int BIT_CLKS = 27,
  parameter int DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] word,
  output logic          active,
  output logic          ser_bit
);
  localparam int NSLOT     = cc_pkg::RUNIN_SLOTS + cc_pkg::START_SLOTS + DW;
  localparam int PH_W      = $clog2(BIT_CLKS);
  localparam int SL_W      = $clog2(NSLOT);
  localparam int IX_W      = $clog2(DW);
  localparam int HALF      = BIT_CLKS / 2;
  localparam int DATA_SLOT = cc_pkg::RUNIN_SLOTS + cc_pkg::START_SLOTS;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CLKS - 1);
  localparam logic [SL_W-1:0] SL_LAST = SL_W'(NSLOT - 1);

  logic            active_q;
  logic [SL_W-1:0] slot_q;
  logic [PH_W-1:0] phase_q;
  logic [SL_W-1:0] didx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      phase_q  <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      slot_q   <= '0;
      phase_q  <= '0;
    end else if (active_q) begin
      if (phase_q == PH_LAST) begin
        phase_q <= '0;
        if (slot_q == SL_LAST) active_q <= 1'b0;
        else                   slot_q   <= slot_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  always_comb begin
    didx    = slot_q - SL_W'(DATA_SLOT);
    ser_bit = 1'b0;
    if (active_q) begin
      if (slot_q < SL_W'(cc_pkg::RUNIN_SLOTS))
        ser_bit = (phase_q < PH_W'(HALF));
      else if (slot_q < SL_W'(DATA_SLOT - 1))
        ser_bit = 1'b0;
      else if (slot_q == SL_W'(DATA_SLOT - 1))
        ser_bit = 1'b1;
      else
        ser_bit = word[didx[IX_W-1:0]];
    end
  end

  assign active = active_q;

  // R3
  win_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> ($past(slot_q) == SL_LAST && $past(phase_q) == PH_LAST));

  // R3
  win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> (slot_q == '0 && phase_q == '0));
endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter #(
  parameter int               H_W      = 11,
  parameter int               LINE_W   = 10,
  parameter int               BIT_CLKS = 27,
  parameter logic [H_W-1:0]   START_H  = 11'd244
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [H_W-1:0]    hcount,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_id,
  input  logic              fmt_pal,
  input  logic              en_f1,
  input  logic              en_f2,
  input  logic              cap_valid,
  output logic              cap_ready,
  input  logic              cap_field,
  input  logic [7:0]        cap_byte1,
  input  logic [7:0]        cap_byte2,
  output logic              cc_valid,
  output logic              cc_bit
);
  localparam int DW = cc_pkg::DATA_BITS;

  logic          hit;
  logic          at_start;
  logic          start;
  logic          active;
  logic          act_field_q;
  logic [DW-1:0] live_word;

  cc_line_match #(.LINE_W(LINE_W)) u_match (
    .field_id (field_id),
    .fmt_pal  (fmt_pal),
    .line_num (line_num),
    .en_f1    (en_f1),
    .en_f2    (en_f2),
    .hit      (hit)
  );

  assign at_start  = (hcount == START_H);
  assign start     = at_start && hit && !active;
  assign cap_ready = !at_start;

  always_ff @(posedge clk) begin
    if (!rst_n)     act_field_q <= 1'b0;
    else if (start) act_field_q <= field_id;
  end

  cc_shadow_bank #(.NF(2), .DW(DW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cap_valid && cap_ready),
    .wr_field   (cap_field),
    .wr_word    ({cap_byte2, cap_byte1}),
    .load       (start),
    .load_field (field_id),
    .sel_field  (act_field_q),
    .active_in  (active),
    .live_word  (live_word)
  );

  cc_serializer #(.BIT_CLKS(BIT_CLKS), .DW(DW)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .word    (live_word),
    .active  (active),
    .ser_bit (cc_bit)
  );

  assign cc_valid = active;

  // R1 R2
  line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_valid) |-> ($past(hit) && $past(at_start)));
endmodule

// File: tb/cc_line_inserter_tb.sv
module cc_line_inserter_tb;
  localparam int CLK_NS = 10;
  localparam int B      = 5;
  localparam int S      = 8;
  localparam int NSLOT  = 26;
  localparam int HEND   = S + NSLOT * B + 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [10:0] hcount = '0;
  logic [9:0] line_num = '0;
  logic       field_id = 1'b0, fmt_pal = 1'b0, en_f1 = 1'b1, en_f2 = 1'b1;
  logic       cap_valid = 1'b0, cap_field = 1'b0;
  logic [7:0] cap_byte1 = '0, cap_byte2 = '0;
  logic       cap_ready, cc_valid, cc_bit;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] pend1 [2];
  logic [7:0] pend2 [2];
  logic [7:0] live1 [2];
  logic [7:0] live2 [2];

  always #(CLK_NS/2) clk = ~clk;

  cc_line_inserter #(.H_W(11), .LINE_W(10), .BIT_CLKS(B), .START_H(11'(S))) u_dut (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .line_num(line_num),
    .field_id(field_id), .fmt_pal(fmt_pal), .en_f1(en_f1), .en_f2(en_f2),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_field(cap_field),
    .cap_byte1(cap_byte1), .cap_byte2(cap_byte2),
    .cc_valid(cc_valid), .cc_bit(cc_bit)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (line=%0d h=%0d)", req, act, expv, line_num, hcount);
    end
  endtask

  task automatic write_bytes(input logic f, input logic [7:0] b1, input logic [7:0] b2);
    @(negedge clk);
    cap_valid = 1'b1; cap_field = f; cap_byte1 = b1; cap_byte2 = b2;
    #1;
    if (cap_ready) begin pend1[f] = b1; pend2[f] = b2; end
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic run_line(input logic f, input int ln, input logic pal, input logic e1,
                          input logic e2, input bit midw, input logic [7:0] mb1,
                          input logic [7:0] mb2, input string tag);
    bit hit, en_ok, ln_ok;
    @(negedge clk);
    field_id = f; line_num = 10'(ln); fmt_pal = pal; en_f1 = e1; en_f2 = e2;
    ln_ok = (ln == (f ? (pal ? 335 : 284) : (pal ? 22 : 21)));
    en_ok = f ? e2 : e1;
    hit   = ln_ok && en_ok;
    for (int h = 0; h <= HEND; h++) begin
      int  j, slot, ph;
      bit  ev, eb;
      string rq;
      if (h != 0) @(negedge clk);
      hcount = 11'(h);
      if (midw && h == S + 40) begin
        cap_valid = 1'b1; cap_field = f; cap_byte1 = mb1; cap_byte2 = mb2;
      end else begin
        cap_valid = 1'b0;
      end
      #1;
      chk(cap_ready == (h != S), "R10", cap_ready, h != S);
      if (h == S && hit) begin live1[f] = pend1[f]; live2[f] = pend2[f]; end
      if (cap_valid && h != S) begin pend1[f] = mb1; pend2[f] = mb2; end
      @(posedge clk);
      #1;
      j  = h - S;
      ev = hit && h >= S && j < NSLOT * B;
      eb = 1'b0;
      rq = !en_ok && ln_ok ? "R8" : (!ln_ok ? "R7" : (f ? "R2" : "R1"));
      if (hit && (j == 0 || j == NSLOT * B - 1 || j == NSLOT * B)) rq = "R3";
      if (ev) begin
        slot = j / B; ph = j % B;
        if (slot < 7) begin eb = (ph < B / 2); if (tag == "") rq = "R4"; end
        else if (slot < 10) begin eb = (slot == 9); if (tag == "") rq = "R5"; end
        else if (slot < 18) begin eb = live1[f][slot-10]; if (tag == "") rq = "R6"; end
        else begin eb = live2[f][slot-18]; if (tag == "") rq = "R6"; end
      end
      if (tag != "") rq = tag;
      chk(cc_valid == ev, rq, cc_valid, ev);
      chk(cc_bit == eb, rq, cc_bit, eb);
    end
    cap_valid = 1'b0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lines [10] = '{20, 21, 22, 23, 283, 284, 285, 334, 335, 336};
    int k = 0;
    for (int i = 0; i < 2; i++) begin
      pend1[i] = '0; pend2[i] = '0; live1[i] = '0; live2[i] = '0;
    end
    repeat (4) @(posedge clk);
    #1;
    // R7 reset state, R10 ready outside start position
    chk(cc_valid == 1'b0, "R7", cc_valid, 0);
    chk(cc_bit == 1'b0, "R7", cc_bit, 0);
    chk(cap_ready == 1'b1, "R10", cap_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R4 R5 R6 R7 sweep over formats, fields and lines around targets
    for (int pal = 0; pal < 2; pal++)
      for (int f = 0; f < 2; f++)
        for (int li = 0; li < 10; li++) begin
          k++;
          write_bytes(f[0], 8'(k * 37 + 5), 8'(k * 91 + 200));
          run_line(f[0], lines[li], pal[0], 1'b1, 1'b1, 1'b0, 8'h0, 8'h0, "");
        end

    // R8 per-field enables
    write_bytes(1'b0, 8'h5A, 8'hC3);
    run_line(1'b0, 21, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0, 8'h0, "R8");
    write_bytes(1'b1, 8'h96, 8'h0F);
    run_line(1'b1, 335, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0, 8'h0, "R8");

    // R9 double buffering: mid-window write only affects next line of that field
    write_bytes(1'b0, 8'h11, 8'h22);
    run_line(1'b0, 21, 1'b0, 1'b1, 1'b1, 1'b1, 8'hE7, 8'h3C, "R9");
    write_bytes(1'b1, 8'hFF, 8'hFF);
    run_line(1'b0, 21, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0, 8'h0, "R9");
    run_line(1'b1, 284, 1'b0, 1'b1, 1'b1, 1'b0, 8'h0, 8'h0, "R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule